// File: doc/BRIEF.md
# Stride-Hinted Cache Fill Controller

This block sits between the miss path of a processor data cache and memory. Every demand miss it accepts becomes a short, ordered burst of single-word read requests. Which extra words join the demanded one depends on a fetch policy that software loads through a hint port. There are three persistent policies. The default fetches the next consecutive words. The stride policy fetches words spaced by a loaded pitch, so a column of a bitmap comes in together. The single policy fetches only the demanded word. A one-shot hint also exists: the next access is delivered without being installed in the cache.

Memory answers the requests in issue order. Each answer is passed back to the cache side with the word address, a flag marking the demanded word, and an allocate flag that tells the cache whether to keep the word. A completion pulse marks the last word of a burst. The controller handles one miss at a time.

Top module: `stride_fill_ctrl`

## Requirements
- R1: After reset the controller is idle: miss_ready is 1, mreq_valid, fill_valid and fill_done are 0, and the first miss uses consecutive fetching with allocation.
- R2: In consecutive mode an accepted miss at word address A issues exactly four requests, in the order A, A+1, A+2, A+3.
- R3: hint_kind 1 loads hint_stride S (unsigned, in words) and selects stride mode. Each later miss at A issues A, A+S, A+2S, A+3S in that order, and the mode persists across misses.
- R4: hint_kind 2 selects single mode. Each later miss issues only the demanded address, and the mode persists.
- R5: hint_kind 3 arms a one-shot no-allocate. The next accepted miss issues only the demanded word, and it is delivered with fill_alloc 0. The miss after that follows the persistent mode again, with fill_alloc 1.
- R6: A hint that is accepted during a fill, or in the same cycle as a miss handshake, does not change that fill. It applies from the next accepted miss.
- R7: miss_ready is 0 from the cycle after a miss handshake until the burst completes. The first request is presented in the cycle after the handshake. While mreq_ready is 0, mreq_valid stays 1 and mreq_addr stays stable.
- R8: One cycle after each mrsp_valid, fill_valid is 1 with the address of the matching request, the response data, and fill_demand set for the first word of the burst only. fill_valid is 0 in every other cycle.
- R9: fill_done is 1 only together with the last fill word of a burst, and miss_ready is 1 again in that same cycle.
- R10: Address arithmetic wraps modulo 2^32.
- R11: hint_kind 0 returns the controller to consecutive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hint_valid | input | 1 | Hint present this cycle |
| hint_kind | input | 2 | 0 consecutive, 1 stride, 2 single, 3 no-allocate once |
| hint_stride | input | 16 | Stride in words for hint_kind 1 |
| miss_valid | input | 1 | Demand miss request |
| miss_ready | output | 1 | Controller can accept a miss |
| miss_addr | input | 32 | Demanded word address |
| mreq_valid | output | 1 | Memory read request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | 32 | Word address to read |
| mrsp_valid | input | 1 | Memory response, in request order |
| mrsp_data | input | 32 | Response data |
| fill_valid | output | 1 | Word delivered to the cache |
| fill_addr | output | 32 | Address of the delivered word |
| fill_data | output | 32 | Delivered data |
| fill_demand | output | 1 | Word is the demanded one |
| fill_alloc | output | 1 | Cache should install the word |
| fill_done | output | 1 | Last word of the burst |

## Verification
The first request is due in the cycle after the miss handshake. Each later request is due in the cycle after the previous one is taken. A fill word is due exactly one cycle after its memory response, and fill_done, along with the return of miss_ready, is due in that same cycle. The reference model records each response it drives as a fill that is due next cycle. It compares fill outputs, request address and the ready signals one nanosecond after each falling edge, so every output it reads has settled after the edge that produced it. Memory readiness and response gaps are varied to stretch these windows without moving the one-cycle relations.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    // Encoding of the hint_kind port
    typedef enum logic [1:0] {
        HINT_SEQ     = 2'd0,
        HINT_STRIDE  = 2'd1,
        HINT_SINGLE  = 2'd2,
        HINT_NOALLOC = 2'd3
    } hint_kind_e;

    // Persistent fetch policy
    typedef enum logic [1:0] {
        MODE_SEQ    = 2'd0,
        MODE_STRIDE = 2'd1,
        MODE_SINGLE = 2'd2
    } fill_mode_e;

endpackage

// File: rtl/sfc_hint_state.sv
module sfc_hint_state
    import sfc_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hint_valid,
    input  logic [1:0]    hint_kind,
    input  logic [SW-1:0] hint_stride,
    input  logic          consume,
    output fill_mode_e    mode_o,
    output logic [SW-1:0] stride_o,
    output logic          noalloc_o
);

    typedef struct packed {
        fill_mode_e    mode;
        logic [SW-1:0] stride;
        logic          noalloc;
    } hint_st_t;

    hint_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the one-shot is used up by the miss that sampled it
        if (consume) st_d.noalloc = 1'b0;
        if (hint_valid) begin
            case (hint_kind_e'(hint_kind))
                HINT_SEQ:     st_d.mode = MODE_SEQ;
                HINT_STRIDE: begin
                    st_d.mode   = MODE_STRIDE;
                    st_d.stride = hint_stride;
                end
                HINT_SINGLE:  st_d.mode = MODE_SINGLE;
                HINT_NOALLOC: st_d.noalloc = 1'b1;
                default:      st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode    <= MODE_SEQ;
            st_q.stride  <= '0;
            st_q.noalloc <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign stride_o  = st_q.stride;
    assign noalloc_o = st_q.noalloc;

    // R5
    noalloc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !(hint_valid && hint_kind == 2'd3)) |=> !noalloc_o)
        else $error("no-allocate survived the miss that used it");

endmodule

// File: rtl/sfc_req_seq.sv
module sfc_req_seq #(
    parameter int AW = 32,
    parameter int SW = 16,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] step,
    input  logic [IW-1:0] last_idx,
    input  logic          mreq_ready,
    output logic          mreq_valid,
    output logic [AW-1:0] mreq_addr,
    output logic          active
);

    typedef struct packed {
        logic          active;
        logic [AW-1:0] base;
        logic [SW-1:0] step;
        logic [IW-1:0] last;
        logic [IW-1:0] idx;
    } seq_st_t;

    seq_st_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        if (start) begin
            sq_d.active = 1'b1;
            sq_d.base   = base;
            sq_d.step   = step;
            sq_d.last   = last_idx;
            sq_d.idx    = '0;
        end else if (sq_q.active && mreq_ready) begin
            if (sq_q.idx == sq_q.last) sq_d.active = 1'b0;
            else                       sq_d.idx    = sq_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign mreq_valid = sq_q.active;
    assign mreq_addr  = sq_q.base + (AW'(sq_q.idx) * AW'(sq_q.step));
    assign active     = sq_q.active;

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)))
        else $error("request dropped or changed while stalled");

endmodule

// File: rtl/sfc_resp_track.sv
module sfc_resp_track #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 16,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] step,
    input  logic [IW-1:0] last_idx,
    input  logic          alloc,
    input  logic          mrsp_valid,
    input  logic [DW-1:0] mrsp_data,
    output logic          busy,
    output logic          fill_valid,
    output logic [AW-1:0] fill_addr,
    output logic [DW-1:0] fill_data,
    output logic          fill_demand,
    output logic          fill_alloc,
    output logic          fill_done
);

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] base;
        logic [SW-1:0] step;
        logic [IW-1:0] last;
        logic          alloc;
        logic [IW-1:0] idx;
        logic          fv;
        logic [AW-1:0] faddr;
        logic [DW-1:0] fdata;
        logic          fdem;
        logic          falloc;
        logic          fdone;
    } trk_st_t;

    trk_st_t tk_d, tk_q;

    always_comb begin
        tk_d       = tk_q;
        tk_d.fv    = 1'b0;
        tk_d.fdone = 1'b0;
        if (start) begin
            tk_d.busy  = 1'b1;
            tk_d.base  = base;
            tk_d.step  = step;
            tk_d.last  = last_idx;
            tk_d.alloc = alloc;
            tk_d.idx   = '0;
        end else if (tk_q.busy && mrsp_valid) begin
            tk_d.fv     = 1'b1;
            tk_d.faddr  = tk_q.base + (AW'(tk_q.idx) * AW'(tk_q.step));
            tk_d.fdata  = mrsp_data;
            tk_d.fdem   = (tk_q.idx == '0);
            tk_d.falloc = tk_q.alloc;
            tk_d.fdone  = (tk_q.idx == tk_q.last);
            tk_d.busy   = (tk_q.idx != tk_q.last);
            tk_d.idx    = tk_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tk_q <= '0;
        end else begin
            tk_q <= tk_d;
        end
    end

    assign busy        = tk_q.busy;
    assign fill_valid  = tk_q.fv;
    assign fill_addr   = tk_q.faddr;
    assign fill_data   = tk_q.fdata;
    assign fill_demand = tk_q.fdem;
    assign fill_alloc  = tk_q.falloc;
    assign fill_done   = tk_q.fdone;

    // R8
    fill_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> $past(mrsp_valid))
        else $error("fill word without a response");

    // R9
    done_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (fill_valid && !busy))
        else $error("done pulse outside the last word");

endmodule

// File: rtl/stride_fill_ctrl.sv
module stride_fill_ctrl
    import sfc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int SW    = 16,
    parameter int EXTRA = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hint_valid,
    input  logic [1:0]    hint_kind,
    input  logic [SW-1:0] hint_stride,
    input  logic          miss_valid,
    output logic          miss_ready,
    input  logic [AW-1:0] miss_addr,
    output logic          mreq_valid,
    input  logic          mreq_ready,
    output logic [AW-1:0] mreq_addr,
    input  logic          mrsp_valid,
    input  logic [DW-1:0] mrsp_data,
    output logic          fill_valid,
    output logic [AW-1:0] fill_addr,
    output logic [DW-1:0] fill_data,
    output logic          fill_demand,
    output logic          fill_alloc,
    output logic          fill_done
);

    localparam int IW = $clog2(EXTRA + 2);
    localparam logic [IW-1:0] LAST_WIDE = IW'(EXTRA);

    fill_mode_e    cur_mode;
    logic [SW-1:0] cur_stride;
    logic          cur_noalloc;
    logic          accept;
    logic          req_active;
    logic          rsp_busy;

    typedef struct packed {
        logic [SW-1:0] step;
        logic [IW-1:0] last;
        logic          alloc;
    } burst_cfg_t;

    burst_cfg_t cfg_d;

    assign miss_ready = !rsp_busy && !req_active;
    assign accept     = miss_valid && miss_ready;

    // burst shape chosen from the hint state as it stands at the handshake
    always_comb begin
        cfg_d.step  = SW'(1);
        cfg_d.last  = LAST_WIDE;
        cfg_d.alloc = 1'b1;
        if (cur_noalloc) begin
            cfg_d.last  = '0;
            cfg_d.alloc = 1'b0;
        end else begin
            case (cur_mode)
                MODE_STRIDE: cfg_d.step = cur_stride;
                MODE_SINGLE: cfg_d.last = '0;
                default:     cfg_d.step = SW'(1);
            endcase
        end
    end

    sfc_hint_state #(.SW(SW)) u_hint (
        .clk         (clk),
        .rst_n       (rst_n),
        .hint_valid  (hint_valid),
        .hint_kind   (hint_kind),
        .hint_stride (hint_stride),
        .consume     (accept),
        .mode_o      (cur_mode),
        .stride_o    (cur_stride),
        .noalloc_o   (cur_noalloc)
    );

    sfc_req_seq #(.AW(AW), .SW(SW), .IW(IW)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .base       (miss_addr),
        .step       (cfg_d.step),
        .last_idx   (cfg_d.last),
        .mreq_ready (mreq_ready),
        .mreq_valid (mreq_valid),
        .mreq_addr  (mreq_addr),
        .active     (req_active)
    );

    sfc_resp_track #(.AW(AW), .DW(DW), .SW(SW), .IW(IW)) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .base        (miss_addr),
        .step        (cfg_d.step),
        .last_idx    (cfg_d.last),
        .alloc       (cfg_d.alloc),
        .mrsp_valid  (mrsp_valid),
        .mrsp_data   (mrsp_data),
        .busy        (rsp_busy),
        .fill_valid  (fill_valid),
        .fill_addr   (fill_addr),
        .fill_data   (fill_data),
        .fill_demand (fill_demand),
        .fill_alloc  (fill_alloc),
        .fill_done   (fill_done)
    );

    // R7
    miss_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> (!miss_ready && mreq_valid))
        else $error("controller not busy after a miss handshake");

    // R5
    noalloc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_alloc) |-> fill_done)
        else $error("no-allocate burst longer than one word");

endmodule

// File: tb/stride_fill_ctrl_bench.sv
`timescale 1ns/1ps
module stride_fill_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hint_valid;
    logic [1:0]  hint_kind;
    logic [15:0] hint_stride;
    logic        miss_valid;
    logic        miss_ready;
    logic [31:0] miss_addr;
    logic        mreq_valid;
    logic        mreq_ready;
    logic [31:0] mreq_addr;
    logic        mrsp_valid;
    logic [31:0] mrsp_data;
    logic        fill_valid;
    logic [31:0] fill_addr;
    logic [31:0] fill_data;
    logic        fill_demand;
    logic        fill_alloc;
    logic        fill_done;

    always #2 clk = ~clk;

    stride_fill_ctrl u_stride_fill_ctrl (
        .clk(clk), .rst_n(rst_n), .hint_valid(hint_valid), .hint_kind(hint_kind),
        .hint_stride(hint_stride), .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_addr(miss_addr), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
        .mreq_addr(mreq_addr), .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_demand(fill_demand), .fill_alloc(fill_alloc), .fill_done(fill_done)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        dem;
        logic        alloc;
        logic        last;
        logic [3:0]  tag;
    } exp_t;

    exp_t req_q[$];
    exp_t pend_q[$];
    exp_t chk_e, due_e;
    bit   chk_v, due_v;
    int   tests, fails;
    bit   mbusy, accepted, stall, finished;
    int   m_mode;            // 0 consecutive, 1 stride, 2 single
    logic [15:0] m_stride;
    bit   m_na;
    logic [3:0] force_tag;

    function automatic string tname(input logic [3:0] t);
        case (t)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model of one burst, built at the miss handshake
    task automatic model_accept(input logic [31:0] a);
        exp_t e;
        int   n;
        logic [31:0] step;
        logic [3:0]  tag;
        step = (m_mode == 1) ? {16'h0, m_stride} : 32'd1;
        n    = (m_na || m_mode == 2) ? 1 : 4;
        tag  = m_na ? 4'd5 : (m_mode == 1 ? 4'd3 : (m_mode == 2 ? 4'd4 : 4'd2));
        if (force_tag != 0) tag = force_tag;
        force_tag = 0;
        for (int i = 0; i < n; i++) begin
            e.a     = a + step * i;
            e.dem   = (i == 0);
            e.alloc = !m_na;
            e.last  = (i == n - 1);
            e.tag   = tag;
            req_q.push_back(e);
        end
        m_na  = 0;
        mbusy = 1;
    endtask

    task automatic model_hint(input logic [1:0] k, input logic [15:0] s);
        case (k)
            2'd0: m_mode = 0;
            2'd1: begin m_mode = 1; m_stride = s; end
            2'd2: m_mode = 2;
            default: m_na = 1;
        endcase
    endtask

    task automatic cycle();
        chk_v = due_v; chk_e = due_e; due_v = 0;
        mreq_ready = stall ? ($urandom % 3 != 0) : 1'b1;
        if (pend_q.size() > 0 && (!stall || $urandom % 2 == 0)) begin
            due_e = pend_q.pop_front();
            due_v = 1;
            mrsp_valid = 1'b1;
            mrsp_data  = due_e.a ^ 32'hC3A5_0F1E;
        end else begin
            mrsp_valid = 1'b0;
            mrsp_data  = '0;
        end
        #1;
        // fill word due one cycle after its response (R8)
        if (chk_v) begin
            check(fill_valid === 1'b1, "R8", {31'h0, fill_valid}, 32'd1);
            check(fill_addr === chk_e.a, tname(chk_e.tag), fill_addr, chk_e.a);
            check(fill_data === (chk_e.a ^ 32'hC3A5_0F1E), "R8", fill_data, chk_e.a ^ 32'hC3A5_0F1E);
            check(fill_demand === chk_e.dem, "R8", {31'h0, fill_demand}, {31'h0, chk_e.dem});
            check(fill_alloc === chk_e.alloc, tname(chk_e.tag), {31'h0, fill_alloc}, {31'h0, chk_e.alloc});
            check(fill_done === chk_e.last, "R9", {31'h0, fill_done}, {31'h0, chk_e.last});
            if (chk_e.last) mbusy = 0;
        end else begin
            check(fill_valid === 1'b0 && fill_done === 1'b0, "R8", {30'h0, fill_valid, fill_done}, 32'd0);
        end
        // R7 / R9: ready tracks the burst
        check(miss_ready === !mbusy, "R7", {31'h0, miss_ready}, {31'h0, !mbusy});
        check(mreq_valid === (req_q.size() > 0), "R7", {31'h0, mreq_valid}, {31'h0, req_q.size() > 0});
        if (mreq_valid && req_q.size() > 0) begin
            check(mreq_addr === req_q[0].a, tname(req_q[0].tag), mreq_addr, req_q[0].a);
            if (mreq_ready) pend_q.push_back(req_q.pop_front());
        end
        if (miss_valid && miss_ready) begin
            accepted = 1;
            model_accept(miss_addr);
        end
        if (hint_valid) model_hint(hint_kind, hint_stride);
        @(negedge clk);
    endtask

    task automatic do_miss(input logic [31:0] a);
        miss_addr  = a;
        miss_valid = 1'b1;
        accepted   = 0;
        while (!accepted) cycle();
        miss_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (mbusy || req_q.size() > 0 || pend_q.size() > 0 || due_v) cycle();
        cycle();
    endtask

    task automatic do_hint(input logic [1:0] k, input logic [15:0] s);
        hint_valid  = 1'b1;
        hint_kind   = k;
        hint_stride = s;
        cycle();
        hint_valid  = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        rst_n = 0; hint_valid = 0; hint_kind = 0; hint_stride = 0;
        miss_valid = 0; miss_addr = 0; mreq_ready = 1; mrsp_valid = 0; mrsp_data = 0;
        m_mode = 0; m_stride = 0; m_na = 0; force_tag = 0; stall = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // R1: idle after reset
        check(miss_ready === 1'b1, "R1", {31'h0, miss_ready}, 32'd1);
        check(mreq_valid === 1'b0, "R1", {31'h0, mreq_valid}, 32'd0);
        check(fill_valid === 1'b0 && fill_done === 1'b0, "R1", {30'h0, fill_valid, fill_done}, 32'd0);
        @(negedge clk);

        force_tag = 4'd1; do_miss(32'h0000_1000); wait_idle();     // R1 default mode
        do_miss(32'h0000_2004); wait_idle();                        // R2
        stall = 1; do_miss(32'h0000_3000); wait_idle(); stall = 0;  // R2, R7 stalls

        do_hint(2'd1, 16'd32);                                      // R3
        do_miss(32'h0000_4000); wait_idle();
        do_miss(32'h0000_5010); wait_idle();                        // R3 persists

        do_miss(32'h0000_6000);                                     // R6 hint during fill
        do_hint(2'd2, 16'd0);
        wait_idle();
        force_tag = 4'd6; do_miss(32'h0000_6100); wait_idle();
        do_miss(32'h0000_7000); wait_idle();                        // R4 persists

        do_hint(2'd3, 16'd0);                                       // R5
        do_miss(32'h0000_8000); wait_idle();
        force_tag = 4'd5; do_miss(32'h0000_8100); wait_idle();

        do_hint(2'd0, 16'd0);                                       // R11
        force_tag = 4'd11; do_miss(32'h0000_9000); wait_idle();

        do_hint(2'd1, 16'h0100);                                    // R10
        force_tag = 4'd10; do_miss(32'hFFFF_FE80); wait_idle();

        hint_valid = 1; hint_kind = 2'd3; hint_stride = 0;          // R6 same-cycle hint
        force_tag = 4'd6; do_miss(32'h0000_A000);
        hint_valid = 0;
        wait_idle();
        force_tag = 4'd6; do_miss(32'h0000_A040); wait_idle();

        do_hint(2'd1, 16'hFFFF);                                    // R10 max stride
        stall = 1;
        force_tag = 4'd10; do_miss(32'hFFFF_0000); wait_idle();
        do_miss(32'h0001_2345); wait_idle();
        stall = 0;

        finish_run();
    end

endmodule